// File: doc/BRIEF.md
# Synchronous Serial Master with Phase and Pin-Inversion Control

This block is a byte-wide serial master. It turns a synchronous serial datapath into an SPI-style link. The host offers a byte with a one-cycle write strobe. The block then produces the serial clock itself from a divider setting, shifts the byte out on the transmit pin, and shifts a byte in from the receive pin. When the transfer is finished, it reports the received byte with a one-cycle done pulse. The block is always the master. It never accepts an external serial clock.

The four SPI modes come from two separate controls. A phase bit chooses whether data is sampled on the leading or the trailing clock edge. An inversion control flips the clock pin, and the idle level of that pin flips with it. Sampling always happens on the edge opposite to the one where the transmit pin changes. Each half period of the serial clock lasts `divider + 1` system clock cycles, so the serial rate is fclk / (2·(divider+1)). A transfer is 8 bits long. A bit-order control selects MSB-first (the value 0) or LSB-first (the value 1). The phase, inversion, order and divider values are all captured at the write strobe. Changes to them during a transfer cannot damage the transfer in progress.

The controller has three states:
- `ST_IDLE` waits for a strobe. A strobe causes the start transition to `ST_SHIFT`.
- `ST_SHIFT` produces 16 serial clock edges. The final edge causes the last-edge transition to `ST_FINISH`.
- `ST_FINISH` lasts exactly one cycle, during which done is high. It then takes the return transition back to `ST_IDLE`.

Top module: `spi_sync_master`

## Requirements
- R1: A write strobe (`wr_en` high at a clock edge while idle) starts a transfer. `busy` is high from the following cycle for exactly 16·(divider+1) cycles.
- R2: During a transfer `sck_o` toggles exactly 16 times. The k-th toggle (k = 1..16) comes k·(divider+1) cycles after the strobe edge.
- R3: When not transferring, `sck_o` rests at the level of `invert`: low for `invert`=0 and high for `invert`=1. The first toggle of a transfer is therefore rising for `invert`=0 and falling for `invert`=1.
- R4: With `phase`=0, `txd_o` presents the first bit before the first clock edge. `rxd_i` is sampled on the odd-numbered edges (1st, 3rd, …), and `txd_o` changes only on the even-numbered edges.
- R5: With `phase`=1, `txd_o` changes on the odd-numbered edges, starting at the 1st edge. `rxd_i` is sampled on the even-numbered edges (2nd, 4th, …, 16th).
- R6: With `lsb_first`=0, bit 7 is sent and received first. With `lsb_first`=1, bit 0 is first. This applies to both directions.
- R7: `done` is high for exactly one cycle, the cycle after the final clock edge, with `busy` low. `rd_data` then holds the byte received.
- R8: A write strobe while `busy` is high neither starts a transfer nor alters the data of the transfer in progress.
- R9: Changes to `phase`, `lsb_first` or `divider` during a transfer do not alter its timing or its data.
- R10: After a transfer, `txd_o` keeps the last bit sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle |
| wr_data | input | 8 | Byte to transmit |
| divider | input | DIV_W | Half-period length minus one, in clock cycles |
| phase | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| invert | input | 1 | Serial clock pin inversion, also sets its idle level |
| lsb_first | input | 1 | 0: MSB first; 1: LSB first |
| rxd_i | input | 1 | Serial receive data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Received byte |
| sck_o | output | 1 | Serial clock |
| txd_o | output | 1 | Serial transmit data |

## Verification
The bench runs every combination of the four clock modes, both bit orders and divider values 0, 1 and 3. Each combination is tried with four byte patterns: a single high bit at either end, and two alternating mixtures. The same transfers also carry an unrelated byte from a bench slave model.

The single-bit patterns show whether the bit order is reversed. The mixed patterns show whether bits slipped by one position, which is what happens when a sample edge is confused with a setup edge. Divider 0 puts edges on consecutive cycles, and it exposes any sampling that collides with a data change. Further transfers pulse the strobe and alter the configuration mid-transfer to show that these values are latched.

// File: rtl/spim_pkg.sv
package spim_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_FINISH = 2'd2
    } spim_state_t;

    typedef struct packed {
        logic phase;
        logic invert;
        logic lsb_first;
    } spim_cfg_t;

endpackage

// File: rtl/spim_baud.sv
// Half-period timer: pulses tick once every (lim+1) cycles while run is high.
module spim_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] lim,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == lim) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == lim);

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && lim != '0) |=> !tick);

endmodule

// File: rtl/spim_ctrl.sv
// Transfer sequencer: state machine, edge counter, clock level, latched setup.
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int BITS  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] divider,
    input  spim_cfg_t        cfg_in,
    input  logic             tick,
    output logic             start,
    output logic [DIV_W-1:0] div_lat,
    output spim_cfg_t        cfg_lat,
    output logic             sample_en,
    output logic             setup_en,
    output logic             last_edge,
    output logic             base_clk,
    output logic             busy,
    output logic             done
);

    localparam int EDGES = 2 * BITS;
    localparam int EW    = $clog2(EDGES);

    spim_state_t    state, state_nx;
    logic [EW-1:0]  edge_cnt;
    logic           odd_pos;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (wr_en)     state_nx = ST_SHIFT;
            ST_SHIFT:  if (last_edge) state_nx = ST_FINISH;
            ST_FINISH:                state_nx = ST_IDLE;
            default:                  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    assign odd_pos = edge_cnt[0];

    always_comb begin
        busy      = (state == ST_SHIFT);
        done      = (state == ST_FINISH);
        start     = (state == ST_IDLE) && wr_en;
        last_edge = tick && (edge_cnt == EW'(EDGES - 1));
        sample_en = tick && (odd_pos == cfg_lat.phase);
        setup_en  = tick && (odd_pos != cfg_lat.phase) && !last_edge;
    end

    // edge bookkeeping and captured setup
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_cnt <= '0;
            base_clk <= 1'b0;
            div_lat  <= '0;
            cfg_lat  <= '0;
        end else if (start) begin
            edge_cnt <= '0;
            base_clk <= 1'b0;
            div_lat  <= divider;
            cfg_lat  <= cfg_in;
        end else if (tick) begin
            edge_cnt <= edge_cnt + 1'b1;
            base_clk <= ~base_clk;
        end
    end

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // R3
    clk_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !base_clk);

    // R8
    write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en && !last_edge) |=> (busy && $stable(cfg_lat)));

endmodule

// File: rtl/spim_shift.sv
// Transmit and receive shift registers with bit-order selection.
module spim_shift #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            phase_in,
    input  logic            lsb_in,
    input  logic            lsb_lat,
    input  logic [BITS-1:0] wr_data,
    input  logic            sample_en,
    input  logic            setup_en,
    input  logic            rxd_i,
    output logic            txd_o,
    output logic [BITS-1:0] rd_data
);

    logic [BITS-1:0] tx_sr, rx_sr, load_rev, rx_rev, load_word;

    for (genvar i = 0; i < BITS; i++) begin : g_rev
        assign load_rev[i] = wr_data[BITS-1-i];
        assign rx_rev[i]   = rx_sr[BITS-1-i];
    end

    assign load_word = lsb_in  ? load_rev : wr_data;
    assign rd_data   = lsb_lat ? rx_rev   : rx_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '0;
            txd_o <= 1'b0;
        end else if (start) begin
            if (phase_in) begin
                tx_sr <= load_word;
            end else begin
                tx_sr <= {load_word[BITS-2:0], 1'b0};
                txd_o <= load_word[BITS-1];
            end
        end else if (setup_en) begin
            txd_o <= tx_sr[BITS-1];
            tx_sr <= {tx_sr[BITS-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sr <= '0;
        end else if (sample_en) begin
            rx_sr <= {rx_sr[BITS-2:0], rxd_i};
        end
    end

    // R4
    txd_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |=> $stable(txd_o));

endmodule

// File: rtl/spi_sync_master.sv
module spi_sync_master
    import spim_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic [DIV_W-1:0] divider,
    input  logic             phase,
    input  logic             invert,
    input  logic             lsb_first,
    input  logic             rxd_i,
    output logic             busy,
    output logic             done,
    output logic [7:0]       rd_data,
    output logic             sck_o,
    output logic             txd_o
);

    localparam int BITS = 8;

    spim_cfg_t        cfg_in, cfg_lat;
    logic [DIV_W-1:0] div_lat;
    logic             tick, start, sample_en, setup_en, last_edge, base_clk;

    assign cfg_in = '{phase: phase, invert: invert, lsb_first: lsb_first};

    spim_baud #(.DIV_W(DIV_W)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .lim  (div_lat),
        .tick (tick)
    );

    spim_ctrl #(.DIV_W(DIV_W), .BITS(BITS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .divider  (divider),
        .cfg_in   (cfg_in),
        .tick     (tick),
        .start    (start),
        .div_lat  (div_lat),
        .cfg_lat  (cfg_lat),
        .sample_en(sample_en),
        .setup_en (setup_en),
        .last_edge(last_edge),
        .base_clk (base_clk),
        .busy     (busy),
        .done     (done)
    );

    spim_shift #(.BITS(BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .phase_in (phase),
        .lsb_in   (lsb_first),
        .lsb_lat  (cfg_lat.lsb_first),
        .wr_data  (wr_data),
        .sample_en(sample_en),
        .setup_en (setup_en),
        .rxd_i    (rxd_i),
        .txd_o    (txd_o),
        .rd_data  (rd_data)
    );

    // pin inversion: captured value while shifting, live value at rest
    assign sck_o = base_clk ^ (busy ? cfg_lat.invert : invert);

    // R3
    sck_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck_o == invert));

    // R2
    sck_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(sck_o));

endmodule

// File: tb/sim_spi_sync_master.sv
module sim_spi_sync_master;

    localparam int DIVW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [7:0]      wr_data = '0;
    logic [DIVW-1:0] divider = '0;
    logic            phase = 1'b0;
    logic            invert = 1'b0;
    logic            lsb_first = 1'b0;
    logic            rxd_i = 1'b0;
    wire             busy, done, sck_o, txd_o;
    wire  [7:0]      rd_data;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    spi_sync_master #(.DIV_W(DIVW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .divider(divider), .phase(phase), .invert(invert),
        .lsb_first(lsb_first), .rxd_i(rxd_i), .busy(busy), .done(done),
        .rd_data(rd_data), .sck_o(sck_o), .txd_o(txd_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic bit_at(input logic [7:0] d, input int i, input bit lsb);
        return lsb ? d[i] : d[7-i];
    endfunction

    task automatic run_xfer(input logic [7:0] mdata, input logic [7:0] sdata,
                            input int div, input bit ph, input bit inv,
                            input bit lsb, input bit disturb);
        logic [7:0] sent;
        logic [7:0] got;
        logic       prev;
        int         n, edges, busy_cnt, late;
        string      txreq;
        sent = '0; edges = 0; busy_cnt = 0; late = 0;
        txreq = ph ? "R5 tx bits" : "R4 tx bits";
        @(negedge clk);
        divider = DIVW'(div); phase = ph; invert = inv; lsb_first = lsb;
        @(negedge clk);
        chk(sck_o == inv, "R3 rest level before", int'(sck_o), int'(inv));
        wr_data = mdata; wr_en = 1'b1;
        rxd_i = bit_at(sdata, 0, lsb);
        prev = sck_o;
        @(negedge clk);
        wr_en = 1'b0;
        n = 1;
        while (n < 5000) begin
            if (busy) busy_cnt++;
            if (sck_o != prev) begin
                if (edges == 0)
                    chk(sck_o == !inv, "R3 leading direction", int'(sck_o), int'(!inv));
                if (n != (edges + 1) * (div + 1) + 1) late++;
                if (((edges % 2) == 0) == (ph == 1'b0)) begin
                    sent[edges / 2] = txd_o;
                end else begin
                    int idx;
                    idx = ph ? edges / 2 : (edges + 1) / 2;
                    if (idx < 8) rxd_i = bit_at(sdata, idx, lsb);
                end
                edges++;
                prev = sck_o;
            end
            if (done) break;
            if (disturb && n == 3) begin
                wr_en = 1'b1; wr_data = ~mdata; phase = !ph;
                lsb_first = !lsb; divider = DIVW'(div + 2);
            end
            if (disturb && n == 4) wr_en = 1'b0;
            @(negedge clk);
            n++;
        end
        for (int i = 0; i < 8; i++) got[lsb ? i : 7 - i] = sent[i];
        chk(busy_cnt == 16 * (div + 1), "R1 busy length", busy_cnt, 16 * (div + 1));
        chk(edges == 16, "R2 toggle count", edges, 16);
        chk(late == 0, "R2 toggle timing", late, 0);
        chk(got == mdata, disturb ? "R9 tx bits" : txreq, int'(got), int'(mdata));
        chk(rd_data == sdata, disturb ? "R8 rx byte" : "R6 rx byte", int'(rd_data), int'(sdata));
        chk(done && !busy, "R7 done with busy low", int'({done, busy}), 2);
        @(negedge clk);
        chk(!done, "R7 done width", int'(done), 0);
        chk(sck_o == invert, "R3 rest level after", int'(sck_o), int'(invert));
        chk(txd_o == bit_at(mdata, 7, lsb), "R10 txd holds last", int'(txd_o),
            int'(bit_at(mdata, 7, lsb)));
        if (disturb) begin
            int seen;
            seen = 0;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (busy) seen++;
            end
            chk(seen == 0, "R8 no restart", seen, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] pats [4];
        int divs [3];
        pats[0] = 8'h80; pats[1] = 8'h01; pats[2] = 8'hA5; pats[3] = 8'h3C;
        divs[0] = 0; divs[1] = 1; divs[2] = 3;
        repeat (3) @(negedge clk);
        // reset state (R1, R3, R7)
        chk(!busy, "R1 reset busy", int'(busy), 0);
        chk(!done, "R7 reset done", int'(done), 0);
        chk(sck_o == 1'b0, "R3 reset level", int'(sck_o), 0);
        rst_n = 1'b1;
        for (int m = 0; m < 4; m++)
            for (int l = 0; l < 2; l++)
                for (int d = 0; d < 3; d++)
                    for (int p = 0; p < 4; p++)
                        run_xfer(pats[p], {pats[p][3:0], pats[p][7:4]} ^ 8'h5A,
                                 divs[d], m[0], m[1], l[0], 1'b0);
        // mid-transfer strobe and setting changes (R8, R9)
        run_xfer(8'hC3, 8'h96, 2, 1'b0, 1'b0, 1'b0, 1'b1);
        run_xfer(8'h4E, 8'h71, 1, 1'b1, 1'b1, 1'b1, 1'b1);
        run_xfer(8'h17, 8'hE8, 0, 1'b1, 1'b0, 1'b0, 1'b1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule